// File: doc/BRIEF.md
# Circular Buffer Flow Controller

This block paces a host link against flash firmware across two ring buffers kept in DRAM, one for each transfer direction. Each ring is cut into equal slots of one virtual page. The page size is picked at initialization from four choices, 4, 8, 16 or 32 KB. The slot count is a power of two, set by a parameter. Each direction keeps a hardware pointer and a hardware limit. The host link steps the pointer one slot per page. Firmware moves the limit. When the pointer runs into the limit, the host side stalls, and no firmware action is needed to stop it.

In the write direction the host fills slots. Firmware moves the write limit forward as it commits filled slots to flash. In the read direction firmware moves the read limit forward as flash reads land in slots. The host then drains slots up to that limit. Each direction emits the DRAM byte address of its current slot. Firmware sees all four pointer and limit registers. A limit update that would retract data already handed over is refused, and a one-cycle error pulse flags it. The region bases and the page size are static inputs, held stable after initialization. The DRAM data movement and the host protocol are outside this block.

Host page events use valid/ready. A write page completes on a cycle where `wr_put_valid` and `wr_put_ready` are both high. A read page is consumed on a cycle where `rd_get_valid` and `rd_get_ready` are both high. Neither ready nor valid depends on the other side's signal in the same cycle. The host may hold its signal high for as long as it likes while the block back-pressures.

Top module: `cbfc_top`

## Requirements
- R1: After reset both pointers and both limits read 0, `wr_put_ready` is 1, `rd_get_valid` is 0 and both error pulses are 0.
- R2: `wr_put_ready` is high exactly when (write pointer + 1) modulo the slot count differs from the write limit. A write handshake steps the write pointer by one, and the pointer wraps from the last slot to slot 0.
- R3: While `wr_put_ready` is low, the write pointer holds whatever `wr_put_valid` does.
- R4: `rd_get_valid` is high exactly when the read pointer differs from the read limit. A read handshake steps the read pointer by one with the same wrap.
- R5: While `rd_get_valid` is low, `rd_get_ready` has no effect and the read pointer holds.
- R6: An accepted limit write shows on the limit readback and acts on ready/valid from the next cycle. With no limit write, the limit holds and no error pulse appears.
- R7: A write-limit update is refused when its forward distance from the old limit exceeds the forward distance from the old limit to the write pointer. A refused update leaves the limit unchanged and raises `wr_lim_err` for exactly the next cycle.
- R8: A read-limit update is refused when its forward distance from the read pointer is smaller than the old limit's forward distance from the read pointer. A refused update leaves the limit unchanged and raises `rd_lim_err` for exactly the next cycle.
- R9: Each slot address equals the region base plus the slot index times the slot size. The slot size is 2^(12+`cfg_page_sel`) bytes, so codes 0 to 3 give 4, 8, 16 and 32 KB.
- R10: A host handshake and a limit write on the same direction in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page_sel | input | 2 | Slot size code: slot is 2^(12+code) bytes |
| cfg_wr_base | input | AW | Byte base of the write ring |
| cfg_rd_base | input | AW | Byte base of the read ring |
| wr_put_valid | input | 1 | Host has completed one page into the current write slot |
| wr_put_ready | output | 1 | Write slot may be completed |
| wr_slot_addr | output | AW | Byte address of the current write slot |
| rd_get_valid | output | 1 | Current read slot holds page data |
| rd_get_ready | input | 1 | Host consumes the current read slot |
| rd_slot_addr | output | AW | Byte address of the current read slot |
| fw_wr_lim_we | input | 1 | Firmware write strobe for the write limit |
| fw_wr_lim_val | input | SLOT_LOG2 | New write limit |
| fw_rd_lim_we | input | 1 | Firmware write strobe for the read limit |
| fw_rd_lim_val | input | SLOT_LOG2 | New read limit |
| wr_ptr_q | output | SLOT_LOG2 | Write pointer readback |
| wr_lim_q | output | SLOT_LOG2 | Write limit readback |
| rd_ptr_q | output | SLOT_LOG2 | Read pointer readback |
| rd_lim_q | output | SLOT_LOG2 | Read limit readback |
| wr_lim_err | output | 1 | One-cycle pulse: write-limit update refused |
| rd_lim_err | output | 1 | One-cycle pulse: read-limit update refused |

## Verification
The assertions check the per-cycle stepping rules on every cycle. A stalled pointer never moves, a handshake moves the pointer by exactly one, a write pointer never steps onto its limit, a refused update leaves its limit untouched, and a limit with no write strobe holds. Other behaviours only show in the bench scenarios. These are the exact accept/refuse boundary of each limit, the point where each direction stalls after a run of pages, wraparound, slot addresses for each page size, and same-cycle handshake with limit update. The bench sweeps every occupancy against every proposed limit value on an 8-slot configuration to cover them.

// File: rtl/cbfc_pkg.sv
package cbfc_pkg;
  // Smallest slot is 4 KB; page-size code adds to this exponent.
  localparam int unsigned SLOT_BYTES_LOG2_MIN = 12;
  localparam int unsigned SHIFT_W = 5;

  typedef enum logic [1:0] {
    PAGE_4K  = 2'd0,
    PAGE_8K  = 2'd1,
    PAGE_16K = 2'd2,
    PAGE_32K = 2'd3
  } page_sel_e;
endpackage

// File: rtl/cbfc_ring.sv
// One direction of pointer/limit flow control.
// PRODUCER=1: host fills slots, firmware releases them (write side).
// PRODUCER=0: firmware fills slots, host drains them (read side).
module cbfc_ring #(
  parameter int unsigned PW       = 3,
  parameter bit          PRODUCER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          lim_we,
  input  logic [PW-1:0] lim_val,
  output logic          host_go,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] lim,
  output logic          lim_err
);
  logic [PW-1:0] ptr_q, lim_q;
  logic [PW-1:0] ptr_inc;
  logic [PW-1:0] dist_new, dist_ref;
  logic          accept, fire, err_q;

  assign ptr_inc = ptr_q + {{(PW-1){1'b0}}, 1'b1};

  generate
    if (PRODUCER) begin : g_prod
      // Free space ends one slot before the limit.
      assign host_go  = (ptr_inc != lim_q);
      // Limit may only advance through slots already filled.
      assign dist_new = lim_val - lim_q;
      assign dist_ref = ptr_q - lim_q;
      assign accept   = (dist_new <= dist_ref);
    end else begin : g_cons
      assign host_go  = (ptr_q != lim_q);
      // Limit may not retract toward the pointer.
      assign dist_new = lim_val - ptr_q;
      assign dist_ref = lim_q - ptr_q;
      assign accept   = (dist_new >= dist_ref);
    end
  endgenerate

  assign fire = host_go & host_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      lim_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (fire) ptr_q <= ptr_inc;
      if (lim_we && accept) lim_q <= lim_val;
      err_q <= lim_we & ~accept;
    end
  end

  assign ptr     = ptr_q;
  assign lim     = lim_q;
  assign lim_err = err_q;
endmodule

// File: rtl/cbfc_slot_addr.sv
// Slot index to DRAM byte address.
module cbfc_slot_addr
  import cbfc_pkg::*;
#(
  parameter int unsigned PW = 3,
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [1:0]    page_sel,
  input  logic [PW-1:0] idx,
  output logic [AW-1:0] addr
);
  logic [SHIFT_W-1:0] sh;
  logic [AW-1:0]      idx_w;

  assign sh    = SHIFT_W'(SLOT_BYTES_LOG2_MIN) + {{(SHIFT_W-2){1'b0}}, page_sel};
  assign idx_w = {{(AW-PW){1'b0}}, idx};
  assign addr  = base + (idx_w << sh);
endmodule

// File: rtl/cbfc_top.sv
// Circular buffer flow controller, both directions.
// SLOT_LOG2 in 1..6 gives 2..64 slots per ring.
module cbfc_top #(
  parameter int unsigned SLOT_LOG2 = 3,
  parameter int unsigned AW        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_page_sel,
  input  logic [AW-1:0]        cfg_wr_base,
  input  logic [AW-1:0]        cfg_rd_base,
  input  logic                 wr_put_valid,
  output logic                 wr_put_ready,
  output logic [AW-1:0]        wr_slot_addr,
  output logic                 rd_get_valid,
  input  logic                 rd_get_ready,
  output logic [AW-1:0]        rd_slot_addr,
  input  logic                 fw_wr_lim_we,
  input  logic [SLOT_LOG2-1:0] fw_wr_lim_val,
  input  logic                 fw_rd_lim_we,
  input  logic [SLOT_LOG2-1:0] fw_rd_lim_val,
  output logic [SLOT_LOG2-1:0] wr_ptr_q,
  output logic [SLOT_LOG2-1:0] wr_lim_q,
  output logic [SLOT_LOG2-1:0] rd_ptr_q,
  output logic [SLOT_LOG2-1:0] rd_lim_q,
  output logic                 wr_lim_err,
  output logic                 rd_lim_err
);
  cbfc_ring #(.PW(SLOT_LOG2), .PRODUCER(1'b1)) u_wr_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_req(wr_put_valid),
    .lim_we  (fw_wr_lim_we),
    .lim_val (fw_wr_lim_val),
    .host_go (wr_put_ready),
    .ptr     (wr_ptr_q),
    .lim     (wr_lim_q),
    .lim_err (wr_lim_err)
  );

  cbfc_ring #(.PW(SLOT_LOG2), .PRODUCER(1'b0)) u_rd_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_req(rd_get_ready),
    .lim_we  (fw_rd_lim_we),
    .lim_val (fw_rd_lim_val),
    .host_go (rd_get_valid),
    .ptr     (rd_ptr_q),
    .lim     (rd_lim_q),
    .lim_err (rd_lim_err)
  );

  cbfc_slot_addr #(.PW(SLOT_LOG2), .AW(AW)) u_wr_addr (
    .base    (cfg_wr_base),
    .page_sel(cfg_page_sel),
    .idx     (wr_ptr_q),
    .addr    (wr_slot_addr)
  );

  cbfc_slot_addr #(.PW(SLOT_LOG2), .AW(AW)) u_rd_addr (
    .base    (cfg_rd_base),
    .page_sel(cfg_page_sel),
    .idx     (rd_ptr_q),
    .addr    (rd_slot_addr)
  );
endmodule

// File: rtl/cbfc_checker.sv
module cbfc_checker #(
  parameter int unsigned PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_put_valid,
  input logic          wr_put_ready,
  input logic          rd_get_valid,
  input logic          rd_get_ready,
  input logic          fw_wr_lim_we,
  input logic          fw_rd_lim_we,
  input logic [PW-1:0] wr_ptr_q,
  input logic [PW-1:0] wr_lim_q,
  input logic [PW-1:0] rd_ptr_q,
  input logic [PW-1:0] rd_lim_q,
  input logic          wr_lim_err,
  input logic          rd_lim_err
);
  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_put_valid && wr_put_ready) |=> (wr_ptr_q == PW'($past(wr_ptr_q) + 1'b1)));

  // R2
  wr_no_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_put_valid && wr_put_ready) |=> (wr_ptr_q != $past(wr_lim_q)));

  // R3
  wr_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_put_ready |=> $stable(wr_ptr_q));

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_get_valid && rd_get_ready) |=> (rd_ptr_q == PW'($past(rd_ptr_q) + 1'b1)));

  // R5
  rd_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_get_valid |=> $stable(rd_ptr_q));

  // R6
  wr_lim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_wr_lim_we |=> ($stable(wr_lim_q) && !wr_lim_err));

  // R6
  rd_lim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_rd_lim_we |=> ($stable(rd_lim_q) && !rd_lim_err));

  // R7
  wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim_err |-> $stable(wr_lim_q));

  // R8
  rd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lim_err |-> $stable(rd_lim_q));
endmodule

bind cbfc_top cbfc_checker #(.PW(SLOT_LOG2)) u_cbfc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_put_valid(wr_put_valid),
  .wr_put_ready(wr_put_ready),
  .rd_get_valid(rd_get_valid),
  .rd_get_ready(rd_get_ready),
  .fw_wr_lim_we(fw_wr_lim_we),
  .fw_rd_lim_we(fw_rd_lim_we),
  .wr_ptr_q    (wr_ptr_q),
  .wr_lim_q    (wr_lim_q),
  .rd_ptr_q    (rd_ptr_q),
  .rd_lim_q    (rd_lim_q),
  .wr_lim_err  (wr_lim_err),
  .rd_lim_err  (rd_lim_err)
);

// File: tb/cbfc_top_tb_top.sv
`timescale 1ns/1ps
module cbfc_top_tb_top;
  localparam int PW = 3;
  localparam int N  = 1 << PW;
  localparam int M  = N - 1;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_page_sel = 2'd0;
  logic [AW-1:0] cfg_wr_base = 32'h4000_0000;
  logic [AW-1:0] cfg_rd_base = 32'h4800_0000;
  logic          wr_put_valid = 1'b0;
  logic          wr_put_ready;
  logic [AW-1:0] wr_slot_addr;
  logic          rd_get_valid;
  logic          rd_get_ready = 1'b0;
  logic [AW-1:0] rd_slot_addr;
  logic          fw_wr_lim_we = 1'b0;
  logic [PW-1:0] fw_wr_lim_val = '0;
  logic          fw_rd_lim_we = 1'b0;
  logic [PW-1:0] fw_rd_lim_val = '0;
  logic [PW-1:0] wr_ptr_q, wr_lim_q, rd_ptr_q, rd_lim_q;
  logic          wr_lim_err, rd_lim_err;

  int checks = 0;
  int errors = 0;
  int m_wp, m_wl, m_rp, m_rl;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cbfc_top #(.SLOT_LOG2(PW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_page_sel(cfg_page_sel),
    .cfg_wr_base(cfg_wr_base), .cfg_rd_base(cfg_rd_base),
    .wr_put_valid(wr_put_valid), .wr_put_ready(wr_put_ready),
    .wr_slot_addr(wr_slot_addr), .rd_get_valid(rd_get_valid),
    .rd_get_ready(rd_get_ready), .rd_slot_addr(rd_slot_addr),
    .fw_wr_lim_we(fw_wr_lim_we), .fw_wr_lim_val(fw_wr_lim_val),
    .fw_rd_lim_we(fw_rd_lim_we), .fw_rd_lim_val(fw_rd_lim_val),
    .wr_ptr_q(wr_ptr_q), .wr_lim_q(wr_lim_q), .rd_ptr_q(rd_ptr_q),
    .rd_lim_q(rd_lim_q), .wr_lim_err(wr_lim_err), .rd_lim_err(rd_lim_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_addr(input logic [31:0] base, input int idx);
    return base + (32'(idx) << (12 + int'(cfg_page_sel)));
  endfunction

  // One cycle: drive at negedge, check pre-edge outputs, check state after edge.
  task automatic tick(input bit wv, input bit rr, input bit wwe, input int wval,
                      input bit rwe, input int rval);
    bit exp_wrdy, exp_rvld, w_acc, r_acc;
    wr_put_valid  = wv;
    rd_get_ready  = rr;
    fw_wr_lim_we  = wwe;
    fw_wr_lim_val = PW'(wval);
    fw_rd_lim_we  = rwe;
    fw_rd_lim_val = PW'(rval);
    exp_wrdy = (((m_wp + 1) & M) != m_wl);
    exp_rvld = (m_rp != m_rl);
    chk("R2 wr_put_ready", 32'(wr_put_ready), 32'(exp_wrdy));
    chk("R4 rd_get_valid", 32'(rd_get_valid), 32'(exp_rvld));
    chk("R9 wr_slot_addr", wr_slot_addr, slot_addr(cfg_wr_base, m_wp));
    chk("R9 rd_slot_addr", rd_slot_addr, slot_addr(cfg_rd_base, m_rp));
    w_acc = (((wval - m_wl) & M) <= ((m_wp - m_wl) & M));
    r_acc = (((rval - m_rp) & M) >= ((m_rl - m_rp) & M));
    @(negedge clk);
    if (wv && exp_wrdy) m_wp = (m_wp + 1) & M;
    if (rr && exp_rvld) m_rp = (m_rp + 1) & M;
    if (wwe && w_acc) m_wl = wval & M;
    if (rwe && r_acc) m_rl = rval & M;
    chk("R3 wr_ptr_q", 32'(wr_ptr_q), 32'(m_wp));
    chk("R5 rd_ptr_q", 32'(rd_ptr_q), 32'(m_rp));
    chk("R6 wr_lim_q", 32'(wr_lim_q), 32'(m_wl));
    chk("R6 rd_lim_q", 32'(rd_lim_q), 32'(m_rl));
    chk("R7 wr_lim_err", 32'(wr_lim_err), 32'(wwe && !w_acc));
    chk("R8 rd_lim_err", 32'(rd_lim_err), 32'(rwe && !r_acc));
    wr_put_valid = 1'b0;
    rd_get_ready = 1'b0;
    fw_wr_lim_we = 1'b0;
    fw_rd_lim_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_wp = 0; m_wl = 0; m_rp = 0; m_rl = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 wr_ptr_q", 32'(wr_ptr_q), 0);
    chk("R1 wr_lim_q", 32'(wr_lim_q), 0);
    chk("R1 rd_ptr_q", 32'(rd_ptr_q), 0);
    chk("R1 rd_lim_q", 32'(rd_lim_q), 0);
    chk("R1 wr_put_ready", 32'(wr_put_ready), 1);
    chk("R1 rd_get_valid", 32'(rd_get_valid), 0);
    chk("R1 errs", 32'({wr_lim_err, rd_lim_err}), 0);

    // R2/R3: fill until stall, host keeps valid high
    for (int i = 0; i < N + 3; i++) tick(1, 0, 0, 0, 0, 0);
    chk("R3 stalled ptr", 32'(wr_ptr_q), 32'(M));
    // R6: release 5 slots, then wrap write pointer around slot 0
    tick(0, 0, 1, 5, 0, 0);
    for (int i = 0; i < 6; i++) tick(1, 0, 0, 0, 0, 0);
    chk("R2 wrapped ptr", 32'(wr_ptr_q), 32'(4));
    // R10: handshake together with limit write
    tick(0, 0, 1, 2, 0, 0);
    tick(1, 0, 1, 4, 0, 0);

    // R5: read ready with nothing valid
    for (int i = 0; i < 3; i++) tick(0, 1, 0, 0, 0, 0);
    // R4: fill and drain with wrap, plus R10 on read side
    tick(0, 0, 0, 0, 1, 6);
    for (int i = 0; i < 4; i++) tick(0, 1, 0, 0, 0, 0);
    tick(0, 1, 0, 0, 1, 2);
    for (int i = 0; i < 6; i++) tick(0, 1, 0, 0, 0, 0);
    chk("R4 wrapped rd ptr", 32'(rd_ptr_q), 32'(2));

    // R7 sweep: every occupancy against every proposed limit
    for (int occ = 0; occ < N; occ++) begin
      for (int nv = 0; nv < N; nv++) begin
        do_reset();
        cfg_page_sel = 2'(nv);
        for (int k = 0; k < occ; k++) tick(1, 0, 0, 0, 0, 0);
        tick(0, 0, 1, nv, 0, 0);
        tick(1, 0, 0, 0, 0, 0);
      end
    end

    // R8/R9 sweep: filled depth, drained count, proposed limit, page size
    for (int f = 0; f < N; f++) begin
      for (int k = 0; k <= f; k++) begin
        for (int nv = 0; nv < N; nv++) begin
          do_reset();
          cfg_page_sel = 2'(f + nv);
          tick(0, 0, 0, 0, 1, f);
          for (int j = 0; j < k; j++) tick(0, 1, 0, 0, 0, 0);
          tick(0, 0, 0, 0, 1, nv);
          tick(0, 1, 0, 0, 0, 0);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-flow actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule